// File: doc/BRIEF.md
# Serial Overhead Port Receiver

This block takes a gated serial stream from an external source and recovers low-order path overhead values from it, such as remote error and defect indications. The source drives a port clock, a valid line and a data line. Each burst on the valid line opens with a three-bit type code. A payload follows, and its length is fixed per type by a parameter. A received payload first waits in a per-type pending register. It is copied to the visible hold register of its type only when the frame-start strobe arrives, so downstream logic sees new values at a fixed point of each frame.

The receiver polices the valid line. A burst that starts before the line has idled long enough is a failure. So is a burst that runs past the length its type allows, and so is a burst whose type code has no length defined. Any failure sets a sticky event bit, which software clears by writing a one. An interrupt follows the event bit unless a mask input is set. While the event bit is set, no burst is accepted.

Top module: `ovh_ser_rx`

## Requirements
- R1: `ser_d`, `ser_vld`, `frame_start`, `evt_clr` and `irq_mask` are sampled on the falling edge of `port_clk`, and all state changes on that edge.
- R2: The first three data bits of a burst form the type code, most significant bit first. The payload that follows is also sent most significant bit first. It is stored right-aligned and zero-extended in bits `[t*PAY_W +: PAY_W]` of `hold_q`, where t is the type code.
- R3: Each type t has a payload length `TYPE_LEN[t]`, with defaults 4,3,1,8,0,2,0,0 for codes 0 to 7. A burst is accepted only if valid falls after exactly 3 + `TYPE_LEN[t]` bits. A shorter burst is dropped and does not raise the event.
- R4: If valid is still high on the sample after 3 + `TYPE_LEN[t]` bits, the burst is an overrun failure and is dropped.
- R5: A type code whose length is 0 is undefined. A burst carrying one is a failure once its header is complete, and it is dropped.
- R6: If valid rises after fewer than `GAP_MIN` low samples since it last fell, that is a failure and the burst is dropped. Exactly `GAP_MIN` low samples are enough.
- R7: `fail_evt` is sticky and is cleared by `evt_clr` = 1. A failure on the same sample as a clear leaves `fail_evt` set.
- R8: `irq` is high exactly when `fail_evt` is 1 and `irq_mask` is 0.
- R9: While `fail_evt` is 1, a complete burst is dropped and its pending value is left untouched.
- R10: `hold_q` changes only on a sample where `frame_start` is 1. Only types with a pending value are updated, and the latest accepted burst of a type wins.
- R11: Reset clears `hold_q`, the pending values and `fail_evt`. A burst that begins before `GAP_MIN` low samples after reset is dropped without raising the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| port_clk | input | 1 | Port clock; sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_d | input | 1 | Serial data |
| ser_vld | input | 1 | Burst valid |
| frame_start | input | 1 | Frame-start strobe that releases pending values |
| evt_clr | input | 1 | Write-one-to-clear for the failure event |
| irq_mask | input | 1 | Interrupt mask, 1 suppresses `irq` |
| hold_q | output | 8*PAY_W | Held values, one PAY_W slice per type code |
| fail_evt | output | 1 | Sticky failure event |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults: `PAY_W` = 8, `GAP_MIN` = 8 and lengths 4,3,1,8,0,2,0,0. These values put three undefined codes, a one-bit payload and a full-width eight-bit payload in the stimulus. Overrun, short-burst and undefined-code cases each take only a few cycles. An idle gap of seven against one of eight separates the gap check by a single sample. One burst moves its data line away from the falling edge, so a receiver that sampled on the wrong edge would capture the wrong bits.

// File: rtl/ovh_ser_rx.sv
module ovh_ser_rx #(
  parameter int PAY_W = 8,
  parameter int GAP_MIN = 8,
  parameter int TYPE_LEN [8] = '{4, 3, 1, 8, 0, 2, 0, 0}
) (
  input  logic               port_clk,
  input  logic               rst_n,
  input  logic               ser_d,
  input  logic               ser_vld,
  input  logic               frame_start,
  input  logic               evt_clr,
  input  logic               irq_mask,
  output logic [8*PAY_W-1:0] hold_q,
  output logic               fail_evt,
  output logic               irq
);
  localparam int NT = 8;
  localparam int CW = $clog2(PAY_W + 4);
  localparam int GW = $clog2(GAP_MIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_DROP} st_t;

  st_t             st;
  logic            vprev, post_rst;
  logic [GW-1:0]   idle;
  logic [CW-1:0]   cnt;
  logic [2:0]      typ;
  logic [PAY_W-1:0] sh;
  logic [NT*PAY_W-1:0] pend;
  logic [NT-1:0]   pflag;

  logic [31:0] len;
  logic hdr_done, undef, full, rise, fall, gap_ok, fail, acc;

  always_comb begin
    len      = 32'(TYPE_LEN[typ]);
    hdr_done = 32'(cnt) >= 3;
    undef    = hdr_done && (len == 0);
    full     = 32'(cnt) == 3 + len;
  end

  assign rise   = ser_vld & ~vprev;
  assign fall   = ~ser_vld & vprev;
  assign gap_ok = 32'(idle) >= GAP_MIN;

  // R4 R5 R6
  assign fail = (rise && !gap_ok && !post_rst) ||
                (st == S_RX && ser_vld && vprev && (undef || full)) ||
                (st == S_RX && fall && undef);
  // R3 R9
  assign acc  = (st == S_RX) && fall && !undef && full && !fail_evt;

  assign irq = fail_evt & ~irq_mask;

  // R1: all state on the falling edge of the port clock
  always_ff @(negedge port_clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vprev    <= 1'b0;
      post_rst <= 1'b1;
      idle     <= '0;
      cnt      <= '0;
      typ      <= '0;
      sh       <= '0;
      fail_evt <= 1'b0;
    end else begin
      vprev <= ser_vld;
      if (ser_vld)      idle <= '0;
      else if (!gap_ok) idle <= idle + 1'b1;
      if (gap_ok) post_rst <= 1'b0;
      fail_evt <= fail | (fail_evt & ~evt_clr);
      unique case (st)
        S_IDLE: if (rise) begin
          if (gap_ok) begin
            st  <= S_RX;
            cnt <= CW'(1);
            typ <= {2'b00, ser_d};
            sh  <= '0;
          end else begin
            st <= S_DROP;
          end
        end
        S_RX: if (!ser_vld) begin
          st <= S_IDLE;
        end else if (fail) begin
          st <= S_DROP;
        end else if (!hdr_done) begin
          typ <= {typ[1:0], ser_d};
          cnt <= cnt + 1'b1;
        end else begin
          sh  <= {sh[PAY_W-2:0], ser_d};
          cnt <= cnt + 1'b1;
        end
        S_DROP: if (!ser_vld) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: per-type pending and hold registers
  for (genvar t = 0; t < NT; t++) begin : g_slot
    logic hit;
    assign hit = acc && (typ == 3'(t));
    always_ff @(negedge port_clk or negedge rst_n) begin
      if (!rst_n) begin
        pflag[t]                 <= 1'b0;
        pend[t*PAY_W +: PAY_W]   <= '0;
        hold_q[t*PAY_W +: PAY_W] <= '0;
      end else begin
        pflag[t] <= hit | (pflag[t] & ~frame_start);
        if (hit) pend[t*PAY_W +: PAY_W] <= sh;
        if (frame_start && pflag[t]) hold_q[t*PAY_W +: PAY_W] <= pend[t*PAY_W +: PAY_W];
      end
    end
  end
endmodule

module ovh_ser_rx_chk #(
  parameter int PAY_W = 8
) (
  input logic               port_clk,
  input logic               rst_n,
  input logic               ser_vld,
  input logic               frame_start,
  input logic               evt_clr,
  input logic               irq_mask,
  input logic [8*PAY_W-1:0] hold_q,
  input logic               fail_evt,
  input logic               irq
);
  // R10
  hold_stable_chk: assert property (@(negedge port_clk) disable iff (!rst_n)
    !frame_start |=> $stable(hold_q));
  // R7
  evt_sticky_chk: assert property (@(negedge port_clk) disable iff (!rst_n)
    fail_evt && !evt_clr |=> fail_evt);
  // R7
  evt_clear_chk: assert property (@(negedge port_clk) disable iff (!rst_n)
    $fell(fail_evt) |-> $past(evt_clr));
  // R8
  irq_gate_chk: assert property (@(negedge port_clk) disable iff (!rst_n)
    irq |-> fail_evt && !irq_mask);
  // R4
  fail_src_chk: assert property (@(negedge port_clk) disable iff (!rst_n)
    $rose(fail_evt) |-> $past(ser_vld) || $past(ser_vld, 2));
endmodule

bind ovh_ser_rx ovh_ser_rx_chk #(.PAY_W(PAY_W)) u_chk (.*);

// File: tb/tb_ovh_ser_rx.sv
module tb_ovh_ser_rx;
  localparam int CLK_P = 10;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_d = 1'b0, ser_vld = 1'b0, frame_start = 1'b0, evt_clr = 1'b0, irq_mask = 1'b0;
  logic [8*PW-1:0] hold_q;
  logic fail_evt, irq;

  int checks = 0, failures = 0;
  logic [7:0] exp_hold [8];

  ovh_ser_rx dut (
    .port_clk(clk), .rst_n(rst_n), .ser_d(ser_d), .ser_vld(ser_vld),
    .frame_start(frame_start), .evt_clr(evt_clr), .irq_mask(irq_mask),
    .hold_q(hold_q), .fail_evt(fail_evt), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  code;
    logic [3:0]  nb;
    logic [7:0]  data;
    logic        bad;
    logic        upd;
    logic [15:0] tag;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 4'd4, 8'h0A, 1'b0, 1'b1, "R2"},
    '{3'd1, 4'd3, 8'h05, 1'b0, 1'b1, "R3"},
    '{3'd3, 4'd8, 8'hC3, 1'b0, 1'b1, "R3"},
    '{3'd2, 4'd1, 8'h01, 1'b0, 1'b1, "R2"},
    '{3'd5, 4'd2, 8'h02, 1'b0, 1'b1, "R3"},
    '{3'd0, 4'd5, 8'h1F, 1'b1, 1'b0, "R4"},
    '{3'd4, 4'd4, 8'h0F, 1'b1, 1'b0, "R5"},
    '{3'd1, 4'd2, 8'h03, 1'b0, 1'b0, "R3"}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); ser_vld = 1'b0; ser_d = 1'b0;
    end
  endtask

  task automatic send(input logic [2:0] code, input int nb, input logic [7:0] data);
    for (int i = 2; i >= 0; i--) begin
      @(posedge clk); ser_vld = 1'b1; ser_d = code[i];
    end
    for (int i = nb - 1; i >= 0; i--) begin
      @(posedge clk); ser_d = data[i];
    end
    @(posedge clk); ser_vld = 1'b0; ser_d = 1'b0;
  endtask

  task automatic send_skew(input logic [2:0] code, input int nb, input logic [7:0] data);
    logic [10:0] bits;
    bits = {code, data};
    for (int i = 0; i < 3 + nb; i++) begin
      logic b;
      b = (i < 3) ? code[2-i] : data[nb-1-(i-3)];
      @(posedge clk); ser_vld = 1'b1; ser_d = ~b;
      #2 ser_d = b;
      #5 ser_d = ~b;
    end
    @(posedge clk); ser_vld = 1'b0; ser_d = 1'b0;
  endtask

  task automatic pulse_fs();
    @(posedge clk); frame_start = 1'b1;
    @(posedge clk); frame_start = 1'b0;
  endtask

  task automatic clr_evt();
    @(posedge clk); evt_clr = 1'b1;
    @(posedge clk); evt_clr = 1'b0;
  endtask

  function automatic logic [7:0] slice(input int t);
    return hold_q[t*PW +: PW];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL timeout: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < 8; t++) exp_hold[t] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check("R11 reset hold", hold_q, '0);
    check("R11 reset event", fail_evt, 0);
    check("R8 reset irq", irq, 0);

    // R11: burst too soon after reset is dropped silently
    idle(1);
    send(3'd0, 4, 8'h05);
    idle(2);
    pulse_fs();
    check("R11 early burst hold", slice(0), 8'h00);
    check("R11 early burst event", fail_evt, 0);
    idle(8);

    for (int v = 0; v < 8; v++) begin
      send(VEC[v].code, int'(VEC[v].nb), VEC[v].data);
      idle(2);
      pulse_fs();
      if (VEC[v].upd) exp_hold[VEC[v].code] = VEC[v].data;
      check($sformatf("%s vector %0d event", VEC[v].tag, v), fail_evt, VEC[v].bad);
      check($sformatf("%s vector %0d hold", VEC[v].tag, v), slice(VEC[v].code), exp_hold[VEC[v].code]);
      if (VEC[v].bad) begin
        check("R8 irq on event", irq, 1);
        clr_evt();
        check("R7 clear", fail_evt, 0);
      end
      idle(8);
    end

    // R10: no update without frame start, latest pending wins
    send(3'd3, 8, 8'h5A);
    idle(3);
    check("R10 held before strobe", slice(3), exp_hold[3]);
    pulse_fs();
    exp_hold[3] = 8'h5A;
    check("R10 after strobe", slice(3), 8'h5A);
    idle(8);
    send(3'd5, 2, 8'h01);
    idle(7);
    send(3'd5, 2, 8'h03);
    idle(2);
    pulse_fs();
    exp_hold[5] = 8'h03;
    check("R10 latest wins", slice(5), 8'h03);
    check("R10 other type kept", slice(0), exp_hold[0]);
    idle(8);

    // R6: exactly GAP_MIN ok, one less fails
    send(3'd0, 4, 8'h09);
    idle(7);
    send(3'd1, 3, 8'h02);
    idle(6);
    send(3'd2, 1, 8'h00);
    idle(2);
    pulse_fs();
    exp_hold[0] = 8'h09;
    exp_hold[1] = 8'h02;
    check("R6 gap fail event", fail_evt, 1);
    check("R6 exact gap accepted", slice(1), 8'h02);
    check("R6 short gap dropped", slice(2), exp_hold[2]);

    // R9: bursts ignored while event set
    idle(8);
    send(3'd0, 4, 8'h03);
    idle(2);
    pulse_fs();
    check("R9 ignored while event", slice(0), 8'h09);

    // R8: mask
    @(posedge clk); irq_mask = 1'b1;
    #1 check("R8 masked irq", irq, 0);
    @(posedge clk); irq_mask = 1'b0;
    #1 check("R8 unmasked irq", irq, 1);

    // R7: clear, then set wins over clear
    clr_evt();
    check("R7 cleared", fail_evt, 0);
    idle(8);
    send(3'd3, 8, 8'h11);
    idle(2);
    send(3'd3, 8, 8'h22);
    idle(2);
    @(posedge clk); ser_vld = 1'b1; evt_clr = 1'b1;
    @(posedge clk); ser_vld = 1'b0; evt_clr = 1'b0;
    idle(2);
    check("R7 set beats clear", fail_evt, 1);
    clr_evt();
    check("R7 clear alone", fail_evt, 0);
    idle(8);
    pulse_fs();
    exp_hold[3] = 8'h11;
    check("R6 first burst kept", slice(3), 8'h11);

    // R1: data valid only around the falling edge
    idle(8);
    send_skew(3'd1, 3, 8'h06);
    idle(2);
    pulse_fs();
    exp_hold[1] = 8'h06;
    check("R1 falling-edge sample", slice(1), 8'h06);
    check("R1 no event", fail_evt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule